// File: doc/BRIEF.md
# Four-port parallel I/O register controller

This block gives a processor byte-wide register access to four general-purpose parallel ports of unequal width. Port 0 and port 1 have eight pins each, port 2 has four and port 3 has five. For each port software sets an output latch and a direction mask, and it can sample the pins through a read-only input register. Each direction bit selects output when it is 1 and input when it is 0. A pin set as input is driven high, so an undriven line idles at 1. When software samples the input register, every bit set as an output reads back as 1.

Three further byte registers hold configuration that other logic decodes: two pull-up enable masks and an output-mode mask for port 3. This block only stores and returns them. The register bus is a plain synchronous strobe interface with no back-pressure. A write takes effect at the clock edge that samples the write strobe. Read data is registered and appears at the edge that samples the read strobe.

Top module: `gpio_regs`

## Requirements
- R1: After reset every output latch and direction register is zero, so pin_out0/1 drive 0xFF, pin_out2 drives 0xF, pin_out3 drives 0x1F, and bus_rdata is 0x00.
- R2: Output latches are at offsets 0x3C0 (port 0), 0x264 (port 1), 0x3C2 (port 2) and 0x3C3 (port 3). A write stores the write data masked to the port width (0xFF, 0xFF, 0x0F, 0x1F). A read returns that stored value, with unused upper bits read as 0.
- R3: Direction registers are at 0x3E0 to 0x3E3 for ports 0 to 3. They store and read back with the same per-port masks as R2.
- R4: Each port's pins drive (latch OR NOT direction) masked to the port width. A direction bit of 1 means output and 0 means input.
- R5: Input registers at 0x3D0 to 0x3D3 for ports 0 to 3 read (pin_in AND width mask) OR direction, with unused upper bits read as 0.
- R6: The pull-up registers at 0x3B0 (mask 0x7F) and 0x3B1 (mask 0x3F), and the port-3 mode register at 0x3F3 (mask 0x7F), store masked write data and read it back.
- R7: bus_rdata takes the addressed value at the clock edge that samples bus_rd, and holds that value on every cycle without bus_rd.
- R8: Offsets other than those in R2, R3, R5 and R6 read as 0x00. Writes to those offsets and to the input registers change no register and no pin.
- R9: A write to one port's direction register leaves the other ports' directions and pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pin_out0 | output | 8 | Port 0 pin drive |
| pin_in0 | input | 8 | Port 0 pin sense |
| pin_out1 | output | 8 | Port 1 pin drive |
| pin_in1 | input | 8 | Port 1 pin sense |
| pin_out2 | output | 4 | Port 2 pin drive |
| pin_in2 | input | 4 | Port 2 pin sense |
| pin_out3 | output | 5 | Port 3 pin drive |
| pin_in3 | input | 5 | Port 3 pin sense |

## Verification
The assertions assume that the bus inputs are known and stable around each sampling edge. They also assume that bus_rd is never high on a cycle whose result the check then needs to hold. The read-hold and unmapped-read properties rely on the bench issuing each strobe for exactly one cycle. The bench changes bus and pin inputs only on falling edges and returns every strobe low before the next access, so each property sees one clean transaction per edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int NUM_PORTS = 4;
  localparam int NUM_CFG = 3;

  localparam logic [ADDR_W-1:0] LAT0_A = 10'h3C0;
  localparam logic [ADDR_W-1:0] LAT1_A = 10'h264;
  localparam logic [ADDR_W-1:0] LAT2_A = 10'h3C2;
  localparam logic [ADDR_W-1:0] LAT3_A = 10'h3C3;
  localparam logic [ADDR_W-1:0] IN_BASE_A  = 10'h3D0;
  localparam logic [ADDR_W-1:0] DIR_BASE_A = 10'h3E0;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
    case (idx)
      0: return 10'h3B0;
      1: return 10'h3B1;
      default: return 10'h3F3;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] cfg_mask(input int idx);
    case (idx)
      0: return 8'h7F;
      1: return 8'h3F;
      default: return 8'h7F;
    endcase
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == LAT0_A) || (a == LAT1_A) || (a == LAT2_A) || (a == LAT3_A);
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (a == IN_BASE_A + ADDR_W'(i))  hit = 1'b1;
      if (a == DIR_BASE_A + ADDR_W'(i)) hit = 1'b1;
    end
    for (int i = 0; i < NUM_CFG; i++)
      if (a == cfg_addr(i)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] LAT_A = '0,
  parameter logic [ADDR_W-1:0] IN_A  = '0,
  parameter logic [ADDR_W-1:0] DIR_A = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [BYTE_W-1:0] rd_val
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      if (addr == LAT_A) latch_q <= wdata[W-1:0];
      if (addr == DIR_A) dir_q   <= wdata[W-1:0];
    end
  end

  assign pin_out = latch_q | ~dir_q;

  always_comb begin
    rd_val = '0;
    if (addr == LAT_A)      rd_val[W-1:0] = latch_q;
    else if (addr == IN_A)  rd_val[W-1:0] = pin_in | dir_q;
    else if (addr == DIR_A) rd_val[W-1:0] = dir_q;
  end

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == LAT_A) |=> latch_q == $past(wdata[W-1:0]));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == DIR_A) |=> dir_q == $past(wdata[W-1:0]));

  assert_foreign_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != LAT_A && addr != DIR_A) |=> ($stable(latch_q) && $stable(dir_q)));

  assert_input_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == DIR_A && wdata[W-1:0] == '0) |=> pin_out == '1);
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] ADDR = '0,
  parameter logic [BYTE_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  output logic [BYTE_W-1:0] rd_val
);
  logic [BYTE_W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  q <= '0;
    else if (wr && addr == ADDR) q <= wdata & MASK;
  end

  assign rd_val = (addr == ADDR) ? q : '0;

  assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR) |=> q == ($past(wdata) & MASK));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR) |=> $stable(q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int P0_W = 8,
  parameter int P1_W = 8,
  parameter int P2_W = 4,
  parameter int P3_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [P0_W-1:0]   pin_out0,
  input  logic [P0_W-1:0]   pin_in0,
  output logic [P1_W-1:0]   pin_out1,
  input  logic [P1_W-1:0]   pin_in1,
  output logic [P2_W-1:0]   pin_out2,
  input  logic [P2_W-1:0]   pin_in2,
  output logic [P3_W-1:0]   pin_out3,
  input  logic [P3_W-1:0]   pin_in3
);
  localparam int NSRC = NUM_PORTS + NUM_CFG;

  logic [BYTE_W-1:0] src_val [NSRC];
  logic [BYTE_W-1:0] rd_mux;

  gpio_port #(.W(P0_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LAT_A(LAT0_A),
              .IN_A(IN_BASE_A + ADDR_W'(0)), .DIR_A(DIR_BASE_A + ADDR_W'(0)))
    u_port0 (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
             .pin_in(pin_in0), .pin_out(pin_out0), .rd_val(src_val[0]));

  gpio_port #(.W(P1_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LAT_A(LAT1_A),
              .IN_A(IN_BASE_A + ADDR_W'(1)), .DIR_A(DIR_BASE_A + ADDR_W'(1)))
    u_port1 (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
             .pin_in(pin_in1), .pin_out(pin_out1), .rd_val(src_val[1]));

  gpio_port #(.W(P2_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LAT_A(LAT2_A),
              .IN_A(IN_BASE_A + ADDR_W'(2)), .DIR_A(DIR_BASE_A + ADDR_W'(2)))
    u_port2 (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
             .pin_in(pin_in2), .pin_out(pin_out2), .rd_val(src_val[2]));

  gpio_port #(.W(P3_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LAT_A(LAT3_A),
              .IN_A(IN_BASE_A + ADDR_W'(3)), .DIR_A(DIR_BASE_A + ADDR_W'(3)))
    u_port3 (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
             .pin_in(pin_in3), .pin_out(pin_out3), .rd_val(src_val[3]));

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    gpio_cfg_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ADDR(cfg_addr(c)), .MASK(cfg_mask(c)))
      u_cfg (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
             .rd_val(src_val[NUM_PORTS + c]));
  end

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSRC; s++) rd_mux = rd_mux | src_val[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_addr)) |=> bus_rdata == '0);

  assert_in_reg_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == IN_BASE_A && pin_in0 == '1) |=> bus_rdata == 8'hFF);
endmodule

// File: tb/test_gpio_regs.sv
module test_gpio_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_out0, pin_out1, pin_in0 = '0, pin_in1 = '0;
  logic [3:0] pin_out2, pin_in2 = '0;
  logic [4:0] pin_out3, pin_in3 = '0;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  gpio_regs i_gpio_regs (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_out0(pin_out0), .pin_in0(pin_in0), .pin_out1(pin_out1), .pin_in1(pin_in1),
    .pin_out2(pin_out2), .pin_in2(pin_in2), .pin_out3(pin_out3), .pin_in3(pin_in3));

  function automatic logic [7:0] pmask(input int p);
    return (p == 2) ? 8'h0F : (p == 3) ? 8'h1F : 8'hFF;
  endfunction
  function automatic logic [9:0] lat_a(input int p);
    case (p) 0: return 10'h3C0; 1: return 10'h264; 2: return 10'h3C2; default: return 10'h3C3; endcase
  endfunction
  function automatic logic [7:0] pin_of(input int p);
    case (p) 0: return pin_out0; 1: return pin_out1; 2: return {4'h0, pin_out2}; default: return {3'h0, pin_out3}; endcase
  endfunction
  task automatic set_pin(input int p, input logic [7:0] v);
    case (p) 0: pin_in0 = v; 1: pin_in1 = v; 2: pin_in2 = v[3:0]; default: pin_in3 = v[4:0]; endcase
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] v, d, dr, pv, hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin0", pin_out0, 8'hFF);
    check("R1 pin1", pin_out1, 8'hFF);
    check("R1 pin2", {4'h0, pin_out2}, 8'h0F);
    check("R1 pin3", {3'h0, pin_out3}, 8'h1F);
    check("R1 rdata", bus_rdata, 8'h00);
    for (int p = 0; p < 4; p++) begin
      rd(lat_a(p), v); check("R1 latch", v, 8'h00);
      rd(10'h3E0 + 10'(p), v); check("R1 dir", v, 8'h00);
    end

    // R2 R3 R4 R5 sweep: latch and direction each cover all 256 values per port
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        d  = 8'(i);
        dr = 8'(i * 29 + 7);
        pv = 8'(~(i * 13));
        set_pin(p, pv);
        wr(lat_a(p), d);
        wr(10'h3E0 + 10'(p), dr);
        check("R4 pin drive", pin_of(p), (d | ~dr) & pmask(p));
        rd(lat_a(p), v);         check("R2 latch readback", v, d & pmask(p));
        rd(10'h3E0 + 10'(p), v); check("R3 dir readback", v, dr & pmask(p));
        rd(10'h3D0 + 10'(p), v); check("R5 input read", v, (pv & pmask(p)) | (dr & pmask(p)));
      end
    end

    // R6 configuration registers
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 256; i++) begin
        logic [9:0] a; logic [7:0] m;
        a = (c == 0) ? 10'h3B0 : (c == 1) ? 10'h3B1 : 10'h3F3;
        m = (c == 1) ? 8'h3F : 8'h7F;
        wr(a, 8'(i));
        rd(a, v); check("R6 cfg readback", v, 8'(i) & m);
      end
    end

    // Known state for R7..R9
    for (int p = 0; p < 4; p++) begin
      wr(lat_a(p), 8'hA5); wr(10'h3E0 + 10'(p), 8'h3C);
    end
    wr(10'h3B0, 8'h55); wr(10'h3B1, 8'h2A); wr(10'h3F3, 8'h11);

    // R7 read data holds between reads
    rd(lat_a(0), hold);
    check("R7 read value", hold, 8'hA5);
    wr(lat_a(0), 8'h0F);
    repeat (3) @(negedge clk);
    check("R7 hold", bus_rdata, 8'hA5);
    wr(lat_a(0), 8'hA5);

    // R8 unmapped offsets and input-register writes
    begin
      logic [9:0] un [10] = '{10'h000, 10'h3C1, 10'h3D4, 10'h3E4, 10'h3F2,
                              10'h3FF, 10'h265, 10'h3B2, 10'h263, 10'h3C4};
      foreach (un[k]) begin
        wr(un[k], 8'hFF);
        rd(un[k], v); check("R8 unmapped read", v, 8'h00);
      end
      for (int p = 0; p < 4; p++) wr(10'h3D0 + 10'(p), 8'hFF);
      for (int p = 0; p < 4; p++) begin
        rd(lat_a(p), v);         check("R8 latch untouched", v, 8'hA5 & pmask(p));
        rd(10'h3E0 + 10'(p), v); check("R8 dir untouched", v, 8'h3C & pmask(p));
        check("R8 pins untouched", pin_of(p), (8'hA5 | ~8'h3C) & pmask(p));
      end
      rd(10'h3B0, v); check("R8 pull-up low untouched", v, 8'h55);
      rd(10'h3B1, v); check("R8 pull-up high untouched", v, 8'h2A);
      rd(10'h3F3, v); check("R8 mode untouched", v, 8'h11);
    end

    // R9 direction write isolation
    wr(10'h3E2, 8'h00);
    check("R9 port2 now input", {4'h0, pin_out2}, 8'h0F);
    for (int p = 0; p < 4; p++) begin
      if (p != 2) begin
        rd(10'h3E0 + 10'(p), v); check("R9 other dir", v, 8'h3C & pmask(p));
        check("R9 other pins", pin_of(p), (8'hA5 | ~8'h3C) & pmask(p));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule